// File: doc/BRIEF.md
# Iterative Byte-Lane Hash Core

The core reduces a message of one or more 32-bit blocks to a 32-bit digest. It keeps four 8-bit chaining words. They are seeded from fixed initial constants when a message starts, and each block updates them through a 64-round compression. Every round takes one clock cycle. In one round the four working words are updated together from byte products with odd multipliers, a fixed left rotation, a right rotation whose amount follows the round index, a XOR with one of sixteen round constants, and one byte of the captured block.

The user pulses `start` to open a message. Blocks are then offered on `msg_blk`, with `src_ready` high and `last_block` marking the final block. A block is taken only while the core is waiting for one. After the marked block has been folded in, `digest` carries the four chaining words and `done` goes high. Both hold until the next `start`.

Top module: `hash_core`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `done` is 0 and `digest` is 0.
- R2: A `start` seen while the core is idle or finished clears `done` at that edge. At the following edge the chaining words load the IV parameter, so `digest` equals IV (chaining word 0 in bits 31:24, word 3 in bits 7:0).
- R3: A block is captured only at an edge where the core is waiting for a block and `src_ready` is 1. Values on `msg_blk`, `src_ready` and `last_block` during the compression of a block do not affect the result.
- R4: Round i (0..63) computes, from the current words and all at once, modulo 256: f = 17*r_i, where r_i is byte (i mod 4) of the block and byte 0 is bits 7:0. It then sets d' = (4c+2)*c, c' = b rotated left by 3, b' = a rotated right by (i mod 8), and a' = ((2d+1)*f) XOR K[i mod 16]. K byte n is held in bits 8n+7:8n of the KTAB parameter.
- R5: Before its rounds, a block copies the chaining words into a, b, c, d. After the rounds, each chaining word adds its matching working word modulo 256. `digest` shows the updated chaining value once each block finishes, including blocks that are not last.
- R6: With capture at edge E, `done` is still 0 after edge E+65 and is 1 after edge E+66 when the captured block was marked last.
- R7: Once high, `done` and `digest` stay unchanged until the next accepted `start`.
- R8: `start` is ignored while a message is in progress.
- R9: While the core waits for a block with `src_ready` low, `digest` does not change and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Opens a new message when the core is idle or finished |
| src_ready | input | 1 | A block is present on `msg_blk` |
| last_block | input | 1 | The present block is the final one of the message |
| msg_blk | input | 32 | Message block; byte 0 is bits 7:0 |
| digest | output | 32 | Chaining words, word 0 in bits 31:24 |
| done | output | 1 | Digest of the whole message is valid |

## Verification
Counting from an accepted `start` edge, the IV shows on `digest` after the second edge, and the core takes a block on the edge after that. From the capture edge, the chaining words change after exactly 66 edges, one copy cycle plus 64 rounds plus one fold cycle. `done` rises after that same edge for a last block. Each bench task drives inputs on the falling edge and then counts rising edges from the capture. It samples `done` after edge 65 and after edge 66, so a single cycle early or late is caught. The bench also drives junk blocks, `src_ready` and `start` during the rounds, and inserts idle waiting cycles, then compares with a byte-level model of the round equations.

// File: rtl/hash_pkg.sv
package hash_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_WAIT,
    ST_COPY,
    ST_ROUND,
    ST_FOLD,
    ST_DONE
  } hstate_e;

  typedef struct packed {
    logic seed;     // load chaining words from IV
    logic take;     // capture message block
    logic copy;     // chaining words into working words
    logic rnd;      // one compression round
    logic fold;     // add working words into chaining words
  } hctl_t;

endpackage

// File: rtl/hash_krom.sv
module hash_krom #(
  parameter int W     = 8,
  parameter int K_CNT = 16,
  parameter int IDX_W = 6,
  parameter logic [K_CNT*W-1:0] KTAB = '0
) (
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     kval
);

  logic [W-1:0] rom [K_CNT];

  for (genvar g = 0; g < K_CNT; g++) begin : g_rom
    assign rom[g] = KTAB[g*W +: W];
  end

  assign kval = rom[int'(idx) % K_CNT];

endmodule

// File: rtl/hash_round.sv
module hash_round #(
  parameter int W    = 8,
  parameter int ROTL = 3,
  localparam int RW  = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  c_i,
  input  logic [W-1:0]  d_i,
  input  logic [W-1:0]  rbyte,
  input  logic [W-1:0]  kbyte,
  input  logic [RW-1:0] ramt,
  output logic [W-1:0]  a_o,
  output logic [W-1:0]  b_o,
  output logic [W-1:0]  c_o,
  output logic [W-1:0]  d_o
);

  logic [W-1:0]   f_v;
  logic [W-1:0]   dodd;
  logic [W-1:0]   e_v;
  logic [W-1:0]   cmul;
  logic [2*W-1:0] a_dbl;

  always_comb begin
    f_v   = rbyte * W'(17);
    dodd  = (d_i << 1) | W'(1);
    e_v   = dodd * f_v;
    cmul  = (c_i << 2) + W'(2);
    d_o   = cmul * c_i;
    c_o   = (b_i << ROTL) | (b_i >> (W - ROTL));
    a_dbl = {a_i, a_i};
    b_o   = a_dbl[int'(ramt) +: W];
    a_o   = e_v ^ kbyte;
  end

endmodule

// File: rtl/hash_ctrl.sv
module hash_ctrl
  import hash_pkg::*;
#(
  parameter int ROUNDS = 64,
  localparam int CNT_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             src_ready,
  input  logic             last_block,
  output hctl_t            ctl,
  output logic [CNT_W-1:0] rnd_idx,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST_RND = CNT_W'(ROUNDS - 1);

  hstate_e          state;
  logic [CNT_W-1:0] cnt;
  logic             last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      last_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_SEED;
        ST_SEED: state <= ST_WAIT;
        ST_WAIT: if (src_ready) begin
          last_q <= last_block;
          state  <= ST_COPY;
        end
        ST_COPY: begin
          cnt   <= '0;
          state <= ST_ROUND;
        end
        ST_ROUND: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == LAST_RND) state <= ST_FOLD;
        end
        ST_FOLD: begin
          if (last_q) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end else begin
            state <= ST_WAIT;
          end
        end
        ST_DONE: if (start) begin
          state <= ST_SEED;
          done  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.seed = (state == ST_SEED);
    ctl.take = (state == ST_WAIT) && src_ready;
    ctl.copy = (state == ST_COPY);
    ctl.rnd  = (state == ST_ROUND);
    ctl.fold = (state == ST_FOLD);
  end

  assign rnd_idx = cnt;

  // R6
  round_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ROUND && cnt != LAST_RND) |=>
      (state == ST_ROUND && cnt == $past(cnt) + CNT_W'(1)));

  // R6
  fold_after_rounds_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ROUND && cnt == LAST_RND) |=> (state == ST_FOLD));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !src_ready) |=> (state == ST_WAIT && !done));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (state == ST_ROUND || state == ST_COPY)) |=> (state != ST_SEED));

endmodule

// File: rtl/hash_datapath.sv
module hash_datapath
  import hash_pkg::*;
#(
  parameter int W      = 8,
  parameter int LANES  = 4,
  parameter int ROUNDS = 64,
  parameter int K_CNT  = 16,
  parameter logic [LANES*W-1:0] IV   = '0,
  parameter logic [K_CNT*W-1:0] KTAB = '0,
  localparam int CNT_W = $clog2(ROUNDS),
  localparam int RW    = $clog2(W),
  localparam int BW    = LANES * W
) (
  input  logic             clk,
  input  logic             rst,
  input  hctl_t            ctl,
  input  logic [CNT_W-1:0] rnd_idx,
  input  logic [BW-1:0]    msg_blk,
  output logic [BW-1:0]    digest
);

  logic [BW-1:0]             r_q;
  logic [LANES-1:0][W-1:0]   h_q;
  logic [LANES-1:0][W-1:0]   w_q;
  logic [LANES-1:0][W-1:0]   w_nx;
  logic [W-1:0]              rbyte;
  logic [W-1:0]              kbyte;
  logic [RW-1:0]             ramt;

  assign rbyte = r_q[(int'(rnd_idx) % LANES) * W +: W];
  assign ramt  = RW'(int'(rnd_idx) % W);

  hash_krom #(
    .W(W), .K_CNT(K_CNT), .IDX_W(CNT_W), .KTAB(KTAB)
  ) u_krom (
    .idx  (rnd_idx),
    .kval (kbyte)
  );

  hash_round #(.W(W), .ROTL(3)) u_round (
    .a_i   (w_q[0]),
    .b_i   (w_q[1]),
    .c_i   (w_q[2]),
    .d_i   (w_q[3]),
    .rbyte (rbyte),
    .kbyte (kbyte),
    .ramt  (ramt),
    .a_o   (w_nx[0]),
    .b_o   (w_nx[1]),
    .c_o   (w_nx[2]),
    .d_o   (w_nx[3])
  );

  always_ff @(posedge clk) begin
    if (rst) r_q <= '0;
    else if (ctl.take) r_q <= msg_blk;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        h_q[j] <= '0;
        w_q[j] <= '0;
      end else begin
        if (ctl.seed)      h_q[j] <= IV[(LANES-1-j)*W +: W];
        else if (ctl.fold) h_q[j] <= h_q[j] + w_q[j];
        if (ctl.copy)      w_q[j] <= h_q[j];
        else if (ctl.rnd)  w_q[j] <= w_nx[j];
      end
    end
    assign digest[(LANES-1-j)*W +: W] = h_q[j];
  end

  // R3
  blk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.take |=> $stable(r_q));

  // R5
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl.seed || ctl.fold) |=> $stable(h_q));

  // R5
  chain_seed_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.seed |=> (digest == IV));

endmodule

// File: rtl/hash_core.sv
module hash_core
  import hash_pkg::*;
#(
  parameter int W      = 8,
  parameter int LANES  = 4,
  parameter int ROUNDS = 64,
  parameter int K_CNT  = 16,
  parameter logic [LANES*W-1:0] IV   = 32'h6A3C_D19E,
  parameter logic [K_CNT*W-1:0] KTAB = 128'hB7E1_5163_9E37_79B9_243F_6A88_85A3_08D3,
  localparam int CNT_W = $clog2(ROUNDS),
  localparam int BW    = LANES * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          src_ready,
  input  logic          last_block,
  input  logic [BW-1:0] msg_blk,
  output logic [BW-1:0] digest,
  output logic          done
);

  hctl_t            ctl;
  logic [CNT_W-1:0] rnd_idx;

  hash_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .src_ready  (src_ready),
    .last_block (last_block),
    .ctl        (ctl),
    .rnd_idx    (rnd_idx),
    .done       (done)
  );

  hash_datapath #(
    .W(W), .LANES(LANES), .ROUNDS(ROUNDS), .K_CNT(K_CNT),
    .IV(IV), .KTAB(KTAB)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .rnd_idx (rnd_idx),
    .msg_blk (msg_blk),
    .digest  (digest)
  );

endmodule

// File: tb/hash_core_tb.sv
module hash_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0]  IV_T = 32'h6A3C_D19E;
  localparam logic [127:0] K_T  = 128'hB7E1_5163_9E37_79B9_243F_6A88_85A3_08D3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        src_ready = 1'b0;
  logic        last_block = 1'b0;
  logic [31:0] msg_blk = '0;
  logic [31:0] digest;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [31:0] chain;

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_core #(.IV(IV_T), .KTAB(K_T)) u_dut (
    .clk(clk), .rst(rst), .start(start), .src_ready(src_ready),
    .last_block(last_block), .msg_blk(msg_blk), .digest(digest), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference compression of one block into a chaining value
  function automatic logic [31:0] ref_block(input logic [31:0] hin, input logic [31:0] blk);
    logic [7:0] h [4];
    logic [7:0] a, b, c, d, f, e, t, na, nb, nc, nd, kb, rb;
    logic [15:0] dbl;
    for (int j = 0; j < 4; j++) h[j] = hin[(3-j)*8 +: 8];
    a = h[0]; b = h[1]; c = h[2]; d = h[3];
    for (int i = 0; i < 64; i++) begin
      kb  = K_T[(i % 16)*8 +: 8];
      rb  = blk[(i % 4)*8 +: 8];
      f   = rb * 8'd17;
      t   = {d[6:0], 1'b1};
      e   = t * f;
      t   = {c[5:0], 2'b10};
      nd  = t * c;
      nc  = {b[4:0], b[7:5]};
      dbl = {a, a};
      nb  = dbl[(i % 8) +: 8];
      na  = e ^ kb;
      a = na; b = nb; c = nc; d = nd;
    end
    h[0] = h[0] + a; h[1] = h[1] + b; h[2] = h[2] + c; h[3] = h[3] + d;
    return {h[0], h[1], h[2], h[3]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; src_ready = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    chk("R1 digest after reset", digest, 32'd0);
  endtask

  task automatic open_msg();
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    chk("R2 done cleared by start", {31'd0, done}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 digest equals IV", digest, IV_T);
    chain = IV_T;
  endtask

  // gap: waiting cycles before the block; noise: junk inputs during rounds
  task automatic feed(input logic [31:0] blk, input logic last, input int gap, input bit noise);
    logic [31:0] held;
    for (int g = 0; g < gap; g++) begin
      msg_blk = $urandom; last_block = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R9 digest stable while waiting", digest, chain);
      chk("R9 done low while waiting", {31'd0, done}, 32'd0);
    end
    msg_blk = blk; last_block = last; src_ready = 1'b1;
    @(posedge clk);                       // capture edge E
    held = chain;
    chain = ref_block(chain, blk);
    for (int n = 1; n <= 65; n++) begin
      @(negedge clk);
      if (noise && n < 60) begin
        msg_blk = ~blk; src_ready = 1'b1; last_block = ~last; start = n[0];
      end else begin
        src_ready = 1'b0; start = 1'b0; msg_blk = 32'h0;
      end
      if (n == 30) chk("R3 chaining unchanged during rounds", digest, held);
      @(posedge clk);
    end
    @(negedge clk);
    src_ready = 1'b0; start = 1'b0;
    chk("R6 done low after E+65", {31'd0, done}, 32'd0);
    @(posedge clk);                       // edge E+66
    @(negedge clk);
    chk("R6 done after E+66", {31'd0, done}, {31'd0, last});
    chk("R4 R5 chaining value after block", digest, chain);
  endtask

  task automatic hold_done(input int cycles);
    logic [31:0] d0;
    d0 = digest;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    chk("R7 done held", {31'd0, done}, 32'd1);
    chk("R7 digest held", digest, d0);
  endtask

  task automatic t_single();
    open_msg();
    feed(32'h0000_0000, 1'b1, 0, 1'b0);
    hold_done(7);
  endtask

  task automatic t_multi();
    open_msg();
    feed(32'h1234_5678, 1'b0, 3, 1'b1);
    feed(32'hDEAD_BEEF, 1'b0, 0, 1'b1);
    feed(32'hA5C3_0F81, 1'b1, 5, 1'b1);
    hold_done(3);
  endtask

  task automatic t_restart_from_done();
    open_msg();
    feed(32'hFFFF_FFFF, 1'b1, 1, 1'b0);
    hold_done(2);
  endtask

  task automatic t_random();
    open_msg();
    for (int k = 0; k < 4; k++) feed($urandom, k == 3, k, k[0]);
  endtask

  task automatic t_reset_mid();
    open_msg();
    msg_blk = 32'h0102_0304; last_block = 1'b1; src_ready = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk); src_ready = 1'b0;
    do_reset();
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk("R1 no completion after mid reset", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_single();
    t_multi();
    t_restart_from_done();
    t_random();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule